// File: doc/BRIEF.md
# Multi-function pad control bank

This block sits between a group of on-chip peripherals and a small bank of I/O pads. Each pad owns one 32-bit control word. The word picks which of eight peripheral signal sets reaches the pad. It can replace that drive with fixed values while the chip is in a low-power state. It also decides where the pull request comes from, and it carries a three-bit drive/slew code out to the pad cell.

On the input side, each pad's level passes through a two-stage synchroniser. Rising and/or falling transitions can then be latched into a sticky per-pad flag. A flagged pad asks the system to wake only when a separate per-pad wake-enable input is also set. Software clears a flag by writing the control word with the clear bit set. The same write switches detection off for that pad.

Top module: `padmux_bank`

## Requirements
- R1: Control bits [2:0] select alternate function k (0 to 7). The pad output and output enable then follow `func_out` and `func_oe` at index pad*8+k.
- R2: Control bits [12:10] appear unchanged on the pad's 3-bit slice of `pad_drv`. The codes are 000 fast 1mA, 001 fast 2mA, 010 fast 3mA, 011 fast 4mA, 100 slow 6mA, 101 fast 6mA, 110 slow 10mA and 111 fast 10mA.
- R3: With bit 15 at 0, the pull requests come from the selected function's `func_pu`/`func_pd` bits. With bit 15 at 1, the pull-up request comes from bit 14 and the pull-down request from bit 13.
- R4: When both pulls are requested, only `pad_pu` is asserted, so a pad never has both pulls active.
- R5: While `lp_mode` is 1 and bit 9 is 1, `pad_out` equals bit 8 and `pad_oe` equals the inverse of bit 7. With bit 9 at 0, or with `lp_mode` at 0, the selected function drives the pad.
- R6: Bit 4 enables rising-edge capture and bit 5 enables falling-edge capture of the synchronised pad input. When both are set, either edge is captured. A captured edge shows on `edge_seen` within four clock cycles of the pad change. A transition whose direction is not enabled leaves the flag at 0.
- R7: A captured edge stays set until the pad's word is written with bit 6 at 1. That write clears the flag and stores bits 4 and 5 as 0. Later transitions on the pad are then not captured.
- R8: `wake_req` is 1 exactly when some pad has both its `edge_seen` bit and its `wake_en` bit set. A captured edge with the wake enable at 0 does not raise it.
- R9: After reset every control word reads 0x00000800 (function 0, drive code 010, no edge detection), and `edge_seen` and `wake_req` are 0.
- R10: Bits 3, 6 and [31:16] always read as 0, and writing them changes no stored field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the addressed control word |
| cfg_sel | input | SEL_W | Pad index for write and read |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Control word of the addressed pad |
| lp_mode | input | 1 | Low-power state active |
| func_out | input | NPADS*8 | Peripheral output per pad and function |
| func_oe | input | NPADS*8 | Peripheral output enable per pad and function |
| func_pu | input | NPADS*8 | Peripheral pull-up request per pad and function |
| func_pd | input | NPADS*8 | Peripheral pull-down request per pad and function |
| pad_in | input | NPADS | Asynchronous pad input levels |
| wake_en | input | NPADS | Per-pad wake enable |
| pad_out | output | NPADS | Data driven to each pad |
| pad_oe | output | NPADS | Output enable to each pad |
| pad_pu | output | NPADS | Pull-up enable to each pad |
| pad_pd | output | NPADS | Pull-down enable to each pad |
| pad_drv | output | NPADS*3 | Drive/slew code per pad |
| edge_seen | output | NPADS | Sticky captured-edge flags |
| wake_req | output | 1 | Wakeup request |

## Verification
The assertions assume that `cfg_sel` names an existing pad whenever `cfg_we` is high. They also assume that `pad_in` is low when reset is released, so that no edge is seen before the first transition. The stimulus writes only to indices below NPADS. It holds every pad input at 0 through reset and changes a pad input only on a falling clock edge. Each change is followed by at least four idle cycles, so the synchroniser has settled before any flag is read.

// File: rtl/padmux_pkg.sv
package padmux_pkg;
  localparam int CFG_W    = 32;
  localparam int AF_W     = 3;
  localparam int NFUNC    = 1 << AF_W;
  localparam int DRV_W    = 3;
  // field positions
  localparam int B_RISE   = 4;
  localparam int B_FALL   = 5;
  localparam int B_CLR    = 6;
  localparam int B_SOE_N  = 7;
  localparam int B_SDAT   = 8;
  localparam int B_SSEL   = 9;
  localparam int B_DRV_LO = 10;
  localparam int B_PD     = 13;
  localparam int B_PU     = 14;
  localparam int B_PSEL   = 15;
  // writable bits: all of [15:0] except 3 and 6
  localparam logic [CFG_W-1:0] CFG_MASK  = 32'h0000_FFB7;
  localparam logic [CFG_W-1:0] CFG_RESET = 32'h0000_0800;

  typedef struct packed {
    logic             psel;
    logic             pu;
    logic             pd;
    logic [DRV_W-1:0] drv;
    logic             ssel;
    logic             sdat;
    logic             soe_n;
    logic             fall;
    logic             rise;
    logic [AF_W-1:0]  af;
  } pad_cfg_t;

  function automatic pad_cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
    pad_cfg_t c;
    c.af    = w[AF_W-1:0];
    c.rise  = w[B_RISE];
    c.fall  = w[B_FALL];
    c.soe_n = w[B_SOE_N];
    c.sdat  = w[B_SDAT];
    c.ssel  = w[B_SSEL];
    c.drv   = w[B_DRV_LO +: DRV_W];
    c.pd    = w[B_PD];
    c.pu    = w[B_PU];
    c.psel  = w[B_PSEL];
    return c;
  endfunction
endpackage

// File: rtl/padmux_cfg_reg.sv
module padmux_cfg_reg
  import padmux_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] cfg,
  output logic             clr_edge
);
  logic [CFG_W-1:0] cfg_d, cfg_q;

  always_comb begin
    cfg_d = cfg_q;
    if (we) begin
      cfg_d = wdata & CFG_MASK;
      if (wdata[B_CLR]) begin
        cfg_d[B_RISE] = 1'b0;
        cfg_d[B_FALL] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg_q <= CFG_RESET;
    else if (we) cfg_q <= cfg_d;
  end

  assign cfg      = cfg_q;
  assign clr_edge = we & wdata[B_CLR];
endmodule

// File: rtl/padmux_edge.sv
module padmux_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pad_in,
  input  logic rise_en,
  input  logic fall_en,
  input  logic clr,
  output logic flag
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic prev_q;
  logic flag_d, flag_q;
  logic lvl, hit;

  assign lvl    = sync_q[SYNC_STAGES-1];
  assign sync_d = {sync_q[SYNC_STAGES-2:0], pad_in};
  assign hit    = (rise_en & lvl & ~prev_q) | (fall_en & ~lvl & prev_q);

  always_comb begin
    flag_d = flag_q;
    if (clr)      flag_d = 1'b0;
    else if (hit) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= lvl;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/padmux_route.sv
module padmux_route
  import padmux_pkg::*;
(
  input  pad_cfg_t         cfg,
  input  logic             lp_mode,
  input  logic [NFUNC-1:0] f_out,
  input  logic [NFUNC-1:0] f_oe,
  input  logic [NFUNC-1:0] f_pu,
  input  logic [NFUNC-1:0] f_pd,
  output logic             o_out,
  output logic             o_oe,
  output logic             o_pu,
  output logic             o_pd,
  output logic [DRV_W-1:0] o_drv
);
  logic pu_req, pd_req, sleep_drive;

  assign sleep_drive = lp_mode & cfg.ssel;

  always_comb begin
    if (sleep_drive) begin
      o_out = cfg.sdat;
      o_oe  = ~cfg.soe_n;
    end else begin
      o_out = f_out[cfg.af];
      o_oe  = f_oe[cfg.af];
    end
    if (cfg.psel) begin
      pu_req = cfg.pu;
      pd_req = cfg.pd;
    end else begin
      pu_req = f_pu[cfg.af];
      pd_req = f_pd[cfg.af];
    end
  end

  assign o_pu  = pu_req;
  assign o_pd  = pd_req & ~pu_req;
  assign o_drv = cfg.drv;
endmodule

// File: rtl/padmux_bank.sv
module padmux_bank
  import padmux_pkg::*;
#(
  parameter int NPADS       = 4,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = (NPADS > 1) ? $clog2(NPADS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [SEL_W-1:0]       cfg_sel,
  input  logic [CFG_W-1:0]       cfg_wdata,
  output logic [CFG_W-1:0]       cfg_rdata,
  input  logic                   lp_mode,
  input  logic [NPADS*NFUNC-1:0] func_out,
  input  logic [NPADS*NFUNC-1:0] func_oe,
  input  logic [NPADS*NFUNC-1:0] func_pu,
  input  logic [NPADS*NFUNC-1:0] func_pd,
  input  logic [NPADS-1:0]       pad_in,
  input  logic [NPADS-1:0]       wake_en,
  output logic [NPADS-1:0]       pad_out,
  output logic [NPADS-1:0]       pad_oe,
  output logic [NPADS-1:0]       pad_pu,
  output logic [NPADS-1:0]       pad_pd,
  output logic [NPADS*DRV_W-1:0] pad_drv,
  output logic [NPADS-1:0]       edge_seen,
  output logic                   wake_req
);
  logic [CFG_W-1:0] cfg_w [NPADS];
  logic [NPADS-1:0] clr_w;

  for (genvar p = 0; p < NPADS; p++) begin : g_pad
    logic     we_p;
    pad_cfg_t dec;

    assign we_p = cfg_we && (cfg_sel == SEL_W'(p));
    assign dec  = unpack_cfg(cfg_w[p]);

    padmux_cfg_reg u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (we_p),
      .wdata    (cfg_wdata),
      .cfg      (cfg_w[p]),
      .clr_edge (clr_w[p])
    );

    padmux_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .pad_in  (pad_in[p]),
      .rise_en (dec.rise),
      .fall_en (dec.fall),
      .clr     (clr_w[p]),
      .flag    (edge_seen[p])
    );

    padmux_route u_route (
      .cfg     (dec),
      .lp_mode (lp_mode),
      .f_out   (func_out[p*NFUNC +: NFUNC]),
      .f_oe    (func_oe[p*NFUNC +: NFUNC]),
      .f_pu    (func_pu[p*NFUNC +: NFUNC]),
      .f_pd    (func_pd[p*NFUNC +: NFUNC]),
      .o_out   (pad_out[p]),
      .o_oe    (pad_oe[p]),
      .o_pu    (pad_pu[p]),
      .o_pd    (pad_pd[p]),
      .o_drv   (pad_drv[p*DRV_W +: DRV_W])
    );
  end

  always_comb begin
    cfg_rdata = '0;
    for (int p = 0; p < NPADS; p++)
      if (cfg_sel == SEL_W'(p)) cfg_rdata = cfg_w[p];
  end

  assign wake_req = |(edge_seen & wake_en);
endmodule

// File: rtl/padmux_bank_chk.sv
module padmux_bank_chk #(
  parameter int NPADS = 4,
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [SEL_W-1:0] cfg_sel,
  input logic [31:0]      cfg_wdata,
  input logic [31:0]      cfg_rdata,
  input logic [NPADS-1:0] pad_pu,
  input logic [NPADS-1:0] pad_pd,
  input logic [NPADS-1:0] wake_en,
  input logic [NPADS-1:0] edge_seen,
  input logic             wake_req
);
  for (genvar p = 0; p < NPADS; p++) begin : g_chk
    logic clr_p;
    assign clr_p = cfg_we && (cfg_sel == SEL_W'(p)) && cfg_wdata[6];

    // R4
    pull_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(pad_pu[p] && pad_pd[p]));

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_seen[p] && !clr_p) |=> edge_seen[p]);

    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_p |=> !edge_seen[p]);

    // R6
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(edge_seen[p]) |-> !$past(clr_p));
  end

  // R8
  wake_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_en == '0) |-> !wake_req);

  // R10
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[31:16] == 16'h0) && !cfg_rdata[6] && !cfg_rdata[3]);
endmodule

bind padmux_bank padmux_bank_chk #(.NPADS(NPADS), .SEL_W(SEL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_sel   (cfg_sel),
  .cfg_wdata (cfg_wdata),
  .cfg_rdata (cfg_rdata),
  .pad_pu    (pad_pu),
  .pad_pd    (pad_pd),
  .wake_en   (wake_en),
  .edge_seen (edge_seen),
  .wake_req  (wake_req)
);

// File: tb/padmux_bank_test.sv
module padmux_bank_test;
  localparam int NP = 4;
  localparam int SW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we;
  logic [SW-1:0] cfg_sel;
  logic [31:0]   cfg_wdata;
  logic [31:0]   cfg_rdata;
  logic          lp_mode;
  logic [NP*8-1:0] func_out, func_oe, func_pu, func_pd;
  logic [NP-1:0] pad_in, wake_en;
  logic [NP-1:0] pad_out, pad_oe, pad_pu, pad_pd, edge_seen;
  logic [NP*3-1:0] pad_drv;
  logic          wake_req;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  padmux_bank #(.NPADS(NP)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lp_mode(lp_mode),
    .func_out(func_out), .func_oe(func_oe), .func_pu(func_pu), .func_pd(func_pd),
    .pad_in(pad_in), .wake_en(wake_en), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_drv(pad_drv),
    .edge_seen(edge_seen), .wake_req(wake_req)
  );

  // {wdata, out, oe, pu, pd, drv} for pad 0, lp_mode = 0
  localparam logic [38:0] VEC [8] = '{
    {32'h0000_0000, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0},
    {32'h0000_0001, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0},
    {32'h0000_1C02, 1'b1, 1'b1, 1'b1, 1'b0, 3'd7},
    {32'h0000_0C04, 1'b0, 1'b1, 1'b0, 1'b1, 3'd3},
    {32'h0000_8007, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0},
    {32'h0000_A005, 1'b1, 1'b0, 1'b0, 1'b1, 3'd0},
    {32'h0000_E003, 1'b0, 1'b1, 1'b1, 1'b0, 3'd0},
    {32'h0000_5006, 1'b0, 1'b1, 1'b0, 1'b0, 3'd4}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input int pad, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = SW'(pad); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0; lp_mode = 1'b0;
    pad_in = '0; wake_en = '0;
    for (int p = 0; p < NP; p++) begin
      func_out[p*8 +: 8] = 8'b1010_0110;
      func_oe [p*8 +: 8] = 8'b0101_1100;
      func_pu [p*8 +: 8] = 8'b0000_1111;
      func_pd [p*8 +: 8] = 8'b0011_0011;
    end
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R9 reset state
    for (int p = 0; p < NP; p++) begin
      cfg_sel = SW'(p);
      @(negedge clk);
      chk("R9 reset word", cfg_rdata, 32'h0000_0800);
    end
    chk("R9 reset drive codes", 32'(pad_drv), 32'(12'b010_010_010_010));
    chk("R9 reset flags", {27'd0, edge_seen, wake_req}, 32'd0);

    // R1 R2 R3 R4 R10 vector walk on pad 0
    for (int v = 0; v < 8; v++) begin
      wr(0, VEC[v][38:7]);
      cfg_sel = 0;
      chk("R1 out/oe", {30'd0, pad_out[0], pad_oe[0]}, {30'd0, VEC[v][6], VEC[v][5]});
      chk("R3 R4 pulls", {30'd0, pad_pu[0], pad_pd[0]}, {30'd0, VEC[v][4], VEC[v][3]});
      chk("R2 drive", {29'd0, pad_drv[2:0]}, {29'd0, VEC[v][2:0]});
      chk("R10 readback", cfg_rdata, VEC[v][38:7] & 32'h0000_FFB7);
    end

    // R10 reserved bits only
    wr(1, 32'hFFFF_0048);
    cfg_sel = 1;
    chk("R10 reserved write", cfg_rdata, 32'h0);
    chk("R10 drive untouched", {29'd0, pad_drv[5:3]}, 32'd0);

    // R5 low-power override
    wr(0, 32'h0000_0301);
    lp_mode = 1'b1; @(negedge clk);
    chk("R5 sleep drive oe on", {30'd0, pad_out[0], pad_oe[0]}, 32'b11);
    wr(0, 32'h0000_0380);
    chk("R5 sleep drive oe off", {30'd0, pad_out[0], pad_oe[0]}, 32'b10);
    lp_mode = 1'b0; @(negedge clk);
    chk("R5 run mode ignores sleep", {30'd0, pad_out[0], pad_oe[0]}, 32'b00);
    wr(0, 32'h0000_0103);
    lp_mode = 1'b1; @(negedge clk);
    chk("R5 sleep sel off", {30'd0, pad_out[0], pad_oe[0]}, 32'b01);
    lp_mode = 1'b0;
    wr(0, 32'h0000_0303);
    chk("R5 run mode sel on", {30'd0, pad_out[0], pad_oe[0]}, 32'b01);

    // R6 rising capture on pad 1, R8 gating
    wr(1, 32'h0000_0010);
    pad_in[1] = 1'b1; idle(4);
    chk("R6 rising captured", {28'd0, edge_seen}, 32'b0010);
    chk("R8 no wake without enable", {31'd0, wake_req}, 32'd0);
    wake_en = 4'b0010; @(negedge clk);
    chk("R8 wake with enable", {31'd0, wake_req}, 32'd1);
    pad_in[1] = 1'b0; idle(4);
    chk("R7 sticky", {28'd0, edge_seen}, 32'b0010);
    wr(1, 32'h0000_0040);
    cfg_sel = 1;
    chk("R7 cleared", {28'd0, edge_seen}, 32'd0);
    chk("R7 detect bits off", cfg_rdata, 32'd0);
    chk("R8 wake drops", {31'd0, wake_req}, 32'd0);
    pad_in[1] = 1'b1; idle(4);
    chk("R7 no capture after clear", {28'd0, edge_seen}, 32'd0);

    // R6 falling-only on pad 2
    wr(2, 32'h0000_0020);
    pad_in[2] = 1'b1; idle(4);
    chk("R6 rising ignored", {28'd0, edge_seen}, 32'd0);
    pad_in[2] = 1'b0; idle(4);
    chk("R6 falling captured", {28'd0, edge_seen}, 32'b0100);

    // R6 both edges on pad 3; R8 not enabled
    wr(3, 32'h0000_0030);
    pad_in[3] = 1'b1; idle(4);
    chk("R6 both-edge rise", {28'd0, edge_seen}, 32'b1100);
    chk("R8 only enabled pads wake", {31'd0, wake_req}, 32'd0);
    wr(3, 32'h0000_0070);
    pad_in[3] = 1'b0; idle(4);
    chk("R6 both-edge fall", {28'd0, edge_seen}, 32'b0100);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule